// File: doc/BRIEF.md
# Timer Capture and Interrupt Status Unit

This block sits next to a free-running timer counter. It watches up to four channel inputs. When a channel is switched on and routed to its own input, any change of that input's level (rising or falling) copies the present counter value into the channel's capture register and raises the channel's event flag. The counter's wrap pulse raises a separate update flag. Software reads the flags from a status register and clears each one by writing a zero to its bit; writing a one to a bit leaves that flag alone. An enable register masks the flags onto a single interrupt line.

The number of channels is a parameter. Control and enable bits that belong to absent channels always read back as zero, so software can count the channels by writing ones and reading the result back. The register bus is a simple synchronous write port with a combinational read port.

Top module: `tcap_unit`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: A channel is armed when its control enable bit (bit 4n+2 at address 2) is 1 and its 2-bit route field (bits 4n+1:4n) holds 01. When the input of an armed channel differs from its value in the previous cycle, the capture register for channel n (address 4+n) takes the `cnt_val` of that cycle, and status bit n+1 is set at the same edge. This applies to both rising and falling edges.
- R3: A channel that is not armed (enable 0, or route other than 01) neither changes its capture register nor sets its flag when its input toggles.
- R4: A capture on a channel whose flag is already set overwrites the capture register with the new count, and the flag stays set.
- R5: Each cycle with `upd_evt` high sets status bit 0.
- R6: A write to the status register (address 0) clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A flag never falls without such a write.
- R7: When a hardware event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: The enable register (address 1) uses the same bit layout as the status register. `irq` is high exactly when some status bit and its enable bit are both 1.
- R9: Control, enable and status bits of channels at or above `NUM_CH` read back 0, and so do their capture registers.
- R10: Capture registers are read-only. Writes to addresses 4 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| cnt_val | input | CNT_W | Current value of the external counter |
| upd_evt | input | 1 | One-cycle pulse on each counter wrap |
| ch_in | input | 4 | Channel inputs, already synchronous to `clk` |
| irq | output | 1 | Interrupt request: OR of the enabled flags |

## Verification
The assertions check the following on every cycle:
- an armed channel edge loads the count and raises its flag on the next edge;
- a channel that is not armed keeps its capture register;
- a wrap pulse always leaves the update flag set;
- no flag falls unless a write carries a zero for it;
- the interrupt stays low while the enable register is zero.

Other properties can only be shown by the bench's scenarios:
- the exact values read back through the bus;
- a recapture overwriting a value whose flag is still set;
- a clear that collides with a new event in the same cycle;
- the masking of absent channels in a two-channel instance;
- the capture registers ignoring writes.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int ADDR_W = 3;
  localparam int MAX_CH = 4;
  localparam int CTRL_STRIDE = 4;
  localparam int CTRL_EN_BIT = 2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [1:0] ROUTE_OWN = 2'b01;
endpackage

// File: rtl/tcap_chan.sv
module tcap_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic             arm,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_hit
);
  logic             prev_q;
  logic [CNT_W-1:0] cap_q, cap_d;

  // Any level change against the last sample counts as an edge.
  always_comb begin
    cap_hit = arm && (sig_in != prev_q);
    cap_d   = cap_q;
    if (cap_hit) cap_d = cnt_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      prev_q <= sig_in;
      if (cap_hit) cap_q <= cap_d;
    end
  end

  assign cap_val = cap_q;
endmodule

// File: rtl/tcap_flags.sv
module tcap_flags #(
  parameter int NFLAG = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] hw_set,
  input  logic             clr_wr,
  input  logic [NFLAG-1:0] clr_data,
  input  logic             ien_wr,
  input  logic [NFLAG-1:0] ien_data,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] ien,
  output logic             irq
);
  logic [NFLAG-1:0] flags_q, flags_d;
  logic [NFLAG-1:0] ien_q, ien_d;
  logic [NFLAG-1:0] kill;

  always_comb begin
    // A zero in the write data kills that flag; hardware sets override.
    kill    = clr_wr ? ~clr_data : '0;
    flags_d = (flags_q & ~kill) | hw_set;
    ien_d   = ien_wr ? ien_data : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ien_q   <= '0;
    end else begin
      flags_q <= flags_d;
      if (ien_wr) ien_q <= ien_d;
    end
  end

  assign flags = flags_q;
  assign ien   = ien_q;
  assign irq   = |(flags_q & ien_q);
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              upd_evt,
  input  logic [MAX_CH-1:0] ch_in,
  output logic              irq
);
  localparam int NFLAG = NUM_CH + 1;
  localparam int FULLF = MAX_CH + 1;

  logic [NUM_CH-1:0]       en_q, en_d;
  logic [NUM_CH-1:0][1:0]  route_q, route_d;
  logic [NUM_CH-1:0]       arm;
  logic [NUM_CH-1:0]       cap_hit;
  logic [NUM_CH*CNT_W-1:0] cap_flat;
  logic [MAX_CH-1:0][CNT_W-1:0] cap_arr;
  logic [NFLAG-1:0]        stat_flags, irq_en;
  logic                    ctrl_wr, stat_wr, ien_wr;
  logic [DATA_W-1:0]       ctrl_rd;

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign ien_wr  = bus_wr && (bus_addr == A_IEN);

  // Channel control next state
  always_comb begin
    en_d    = en_q;
    route_d = route_q;
    if (ctrl_wr) begin
      for (int i = 0; i < NUM_CH; i++) begin
        route_d[i] = bus_wdata[i*CTRL_STRIDE +: 2];
        en_d[i]    = bus_wdata[i*CTRL_STRIDE + CTRL_EN_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
    end else if (ctrl_wr) begin
      en_q    <= en_d;
      route_q <= route_d;
    end
  end

  for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
    if (c < NUM_CH) begin : g_on
      assign arm[c] = en_q[c] && (route_q[c] == ROUTE_OWN);
      tcap_chan #(.CNT_W(CNT_W)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_in  (ch_in[c]),
        .arm     (arm[c]),
        .cnt_val (cnt_val),
        .cap_val (cap_arr[c]),
        .cap_hit (cap_hit[c])
      );
      assign cap_flat[c*CNT_W +: CNT_W] = cap_arr[c];
    end else begin : g_off
      assign cap_arr[c] = '0;
    end
  end

  tcap_flags #(.NFLAG(NFLAG)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_set   ({cap_hit, upd_evt}),
    .clr_wr   (stat_wr),
    .clr_data (bus_wdata[NFLAG-1:0]),
    .ien_wr   (ien_wr),
    .ien_data (bus_wdata[NFLAG-1:0]),
    .flags    (stat_flags),
    .ien      (irq_en),
    .irq      (irq)
  );

  // Read data
  always_comb begin
    ctrl_rd = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      ctrl_rd[i*CTRL_STRIDE +: 2]           = route_q[i];
      ctrl_rd[i*CTRL_STRIDE + CTRL_EN_BIT] = en_q[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[2]) begin
      bus_rdata = DATA_W'(cap_arr[bus_addr[1:0]]);
    end else begin
      case (bus_addr)
        A_STAT:  bus_rdata = DATA_W'(FULLF'(stat_flags));
        A_IEN:   bus_rdata = DATA_W'(FULLF'(irq_en));
        A_CTRL:  bus_rdata = ctrl_rd;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tcap_unit_chk.sv
module tcap_unit_chk
  import tcap_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_wr,
  input logic [DATA_W-1:0]       bus_wdata,
  input logic [CNT_W-1:0]        cnt_val,
  input logic                    upd_evt,
  input logic [MAX_CH-1:0]       ch_in,
  input logic                    irq,
  input logic [NUM_CH:0]         stat_flags,
  input logic [NUM_CH:0]         irq_en,
  input logic [NUM_CH-1:0]       arm,
  input logic [NUM_CH*CNT_W-1:0] cap_flat
);
  logic [NUM_CH-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= ch_in[NUM_CH-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R2
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm[c] && (ch_in[c] != seen_q[c])) |=>
        (cap_flat[c*CNT_W +: CNT_W] == $past(cnt_val)) && stat_flags[c+1]);
    // R3
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arm[c] |=> $stable(cap_flat[c*CNT_W +: CNT_W]));
  end

  for (genvar b = 0; b <= NUM_CH; b++) begin : g_f
    // R6
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_flags[b] && !(bus_wr && (bus_addr == A_STAT) && !bus_wdata[b]))
        |=> stat_flags[b]);
  end

  // R5 R7
  upd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> stat_flags[0]);

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);

  // R8
  irq_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_flags[0] && irq_en[0]) |-> irq);
endmodule

bind tcap_unit tcap_unit_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .cnt_val    (cnt_val),
  .upd_evt    (upd_evt),
  .ch_in      (ch_in),
  .irq        (irq),
  .stat_flags (stat_flags),
  .irq_en     (irq_en),
  .arm        (arm),
  .cap_flat   (cap_flat)
);

// File: tb/tb_tcap_unit.sv
`timescale 1ns/1ps
module tb_tcap_unit;
  logic        clk;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] rdata4, rdata2;
  logic [15:0] cnt_val;
  logic        upd_evt;
  logic [3:0]  ch_in;
  logic        irq4, irq2;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Scoreboard queues: source (0 dut rdata, 1 dut irq, 2 dut2 rdata)
  int          q_src[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  tcap_unit #(.NUM_CH(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata4), .cnt_val(cnt_val),
    .upd_evt(upd_evt), .ch_in(ch_in), .irq(irq4)
  );

  tcap_unit #(.NUM_CH(2)) dut2 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata2), .cnt_val(cnt_val),
    .upd_evt(upd_evt), .ch_in(ch_in), .irq(irq2)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // Monitor: pops one expected item per falling edge and compares.
  initial begin
    forever begin
      @(negedge clk);
      if (q_src.size() > 0) begin
        int          s;
        logic [31:0] e, a;
        string       t;
        s = q_src.pop_front();
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = (s == 0) ? rdata4 : (s == 1) ? {31'd0, irq4} : rdata2;
        n_chk++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", t, a, e);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    tick();
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic expect_item(input int src, input logic [2:0] a,
                             input logic [31:0] e, input string t);
    tick();
    bus_addr = a;
    q_src.push_back(src);
    q_exp.push_back(e);
    q_tag.push_back(t);
    @(negedge clk);
    #1;
  endtask

  // One cycle with the given count and input vector, then park the count.
  task automatic pulse_in(input logic [15:0] c, input logic [3:0] v);
    tick();
    cnt_val = c; ch_in = v;
    tick();
    cnt_val = 16'hDEAD;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    cnt_val = '0; upd_evt = 1'b0; ch_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_item(0, 3'd0, 32'h0, "R1 status");
    expect_item(0, 3'd1, 32'h0, "R1 enable");
    expect_item(0, 3'd2, 32'h0, "R1 control");
    expect_item(0, 3'd4, 32'h0, "R1 capture0");
    expect_item(1, 3'd0, 32'h0, "R1 irq");

    // ch0 armed, ch1 armed, ch2 enabled with wrong route, ch3 routed but off
    wr(3'd2, 32'h0000_1655);
    expect_item(0, 3'd2, 32'h1655, "R2 control readback");
    expect_item(2, 3'd2, 32'h0055, "R9 control two-channel");

    // R2 rising edge on ch0
    pulse_in(16'h1234, 4'b0001);
    expect_item(0, 3'd4, 32'h1234, "R2 capture0 rising");
    expect_item(0, 3'd0, 32'h02,   "R2 flag0");
    // R2 rising edge on ch1
    pulse_in(16'hABCD, 4'b0011);
    expect_item(0, 3'd5, 32'hABCD, "R2 capture1 rising");
    expect_item(0, 3'd0, 32'h06,   "R2 flags 0 and 1");
    // R4 falling edge on ch0 with flag still set
    pulse_in(16'h0042, 4'b0010);
    expect_item(0, 3'd4, 32'h0042, "R4 capture0 overwrite");
    expect_item(0, 3'd0, 32'h06,   "R4 flag stays set");

    // R3 toggles on channels that are not armed
    pulse_in(16'h7777, 4'b1110);
    expect_item(0, 3'd6, 32'h0, "R3 capture2 unchanged");
    expect_item(0, 3'd7, 32'h0, "R3 capture3 unchanged");
    expect_item(0, 3'd0, 32'h06, "R3 no new flag");

    // R6 write-zero clears one flag, write-one has no effect
    wr(3'd0, 32'hFFFF_FFFD);
    expect_item(0, 3'd0, 32'h04, "R6 clear flag0 only");
    wr(3'd0, 32'hFFFF_FFFF);
    expect_item(0, 3'd0, 32'h04, "R6 all-ones write ignored");

    // R5 update pulse
    tick(); upd_evt = 1'b1;
    tick(); upd_evt = 1'b0;
    expect_item(0, 3'd0, 32'h05, "R5 update flag");

    // R8 masking
    expect_item(1, 3'd0, 32'h0, "R8 irq with no enables");
    wr(3'd1, 32'h08);
    expect_item(1, 3'd0, 32'h0, "R8 irq enable on clear flag");
    wr(3'd1, 32'h04);
    expect_item(1, 3'd0, 32'h1, "R8 irq enabled flag1");
    expect_item(0, 3'd1, 32'h04, "R8 enable readback");
    wr(3'd0, 32'hFFFF_FFFB);
    expect_item(1, 3'd0, 32'h0, "R8 irq drops after clear");
    expect_item(0, 3'd0, 32'h01, "R6 clear flag1");

    // R7 clearing write collides with update and ch0 capture
    tick();
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h0;
    upd_evt = 1'b1; cnt_val = 16'h0055; ch_in = 4'b0011;
    tick();
    bus_wr = 1'b0; upd_evt = 1'b0; cnt_val = 16'hDEAD;
    expect_item(0, 3'd0, 32'h03, "R7 set wins over clear");
    expect_item(0, 3'd4, 32'h0055, "R7 capture during clear");

    // R10 capture registers ignore writes
    wr(3'd4, 32'h0000_FFFF);
    expect_item(0, 3'd4, 32'h0055, "R10 capture0 read-only");

    // R9 absent channels in the two-channel instance
    wr(3'd1, 32'h1F);
    expect_item(0, 3'd1, 32'h1F, "R9 enable four channels");
    expect_item(2, 3'd1, 32'h07, "R9 enable two channels");
    expect_item(2, 3'd6, 32'h0,  "R9 absent capture reads zero");
    expect_item(2, 3'd0, 32'h03, "R9 two-channel status");

    repeat (3) tick();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule